// File: doc/BRIEF.md
# Configurable Window Watchdog Supervisor

This block supervises a host processor on behalf of a system-basis controller. The host keeps it quiet by sending refresh command words, already decoded from the serial link, once per watchdog period. Period length is counted in pulses of a clock-enable tick. A configuration register, writable only while the controller sits in its initialization mode, chooses the refresh timing (timeout or window), the refresh style (plain or challenge-response over one, two or four words keyed on an internal pseudo-random code), an optional deadline for acknowledging an interrupt, and how soon the safe-state output is driven.

Any refresh fault (early word, wrong word, missing refresh) or a late interrupt acknowledge produces a fixed-width reset pulse and restarts the period. Consecutive faults without a completed refresh between them are counted, and the safe-state output latches on the first or second one. The current code is published so that the host can compute its answer.

Top module: `wdog_supervisor`

## Requirements
- R1: The configuration register takes `cfg_data_i` only in a cycle where `cfg_we_i` and `init_mode_i` are both high; otherwise it keeps its value. Field positions: bit 0 window enable, bits 2:1 refresh style, bit 3 interrupt deadline enable, bit 4 safe on second fault. A write also discards any partial refresh sequence.
- R2: After `rst_ni` falls, `rst_o` and `safe_o` are 0, the configuration is all zero (timeout, plain refresh, no deadline, safe on first fault), and `code_o` is 16'hACE1.
- R3: The period counter advances on each `tick_i` from 0 to TICKS-1. With window enable set, a command word while the count is below TICKS/2 is a fault; with it clear, a word is accepted at any count.
- R4: With style 2'b00, a single command word of any value completes a refresh.
- R5: With style 2'b01 one word equal to the bitwise complement of `code_o` completes a refresh. With 2'b10 two words carry that complement's high byte then low byte in data bits 7:0. With 2'b11 four words carry its nibbles, most significant first, in data bits 3:0. A mismatching word is a fault.
- R6: `code_o` changes only on a completed refresh, then steps to {code[14:0], code[15]^code[13]^code[12]^code[10]}.
- R7: A `tick_i` while the count is TICKS-1 with no refresh completing in that cycle is a fault. A refresh that completes in that cycle wins and no fault occurs. A completed refresh restarts the count at 0.
- R8: A fault drives `rst_o` high from the next cycle for exactly RST_W cycles. During the pulse all command, tick and interrupt inputs are ignored and the count restarts at 0.
- R9: With deadline enabled, `irq_raise_i` arms a deadline of (3*TICKS - count) ticks, the tick of the raising cycle not counted. If the last of those ticks arrives without `irq_ack_i` in the same or an earlier cycle, it is a fault. A raise while already armed is ignored.
- R10: With deadline disabled, `irq_raise_i` arms nothing and an unacknowledged interrupt never causes a fault.
- R11: With bit 4 clear, `safe_o` rises together with the first fault's pulse; with it set, on the second fault with no completed refresh between. A completed refresh clears the fault count. `safe_o` stays high until `rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | Period time base enable, one cycle per tick |
| init_mode_i | input | 1 | Controller is in initialization mode |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 5 | Configuration write data |
| cmd_valid_i | input | 1 | Refresh command word present |
| cmd_data_i | input | 16 | Refresh command word |
| irq_raise_i | input | 1 | Interrupt raised toward the host |
| irq_ack_i | input | 1 | Host read the interrupt source |
| rst_o | output | 1 | Reset pulse to the host |
| safe_o | output | 1 | Safe-state request, sticky |
| code_o | output | 16 | Current challenge code |

## Verification
Two collisions matter: a refresh finishing in the very cycle whose tick closes the period, and an interrupt acknowledge arriving in the cycle whose tick exhausts the deadline. The bench aligns a command or acknowledge with the final tick by watching its own model's count and the tick input, expects no reset in either case, and then shifts the acknowledge one cycle later to require a reset. A behavioural model advanced every clock judges `rst_o`, `safe_o` and `code_o` in all other cycles too.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    REF_PLAIN = 2'b00,
    REF_ONE   = 2'b01,
    REF_TWO   = 2'b10,
    REF_FOUR  = 2'b11
  } ref_mode_e;

  typedef struct packed {
    logic      safe_second;
    logic      irq_chk;
    ref_mode_e mode;
    logic      window;
  } wd_cfg_t;

  localparam int unsigned CFG_W  = $bits(wd_cfg_t);
  localparam int unsigned CODE_W = 16;

  function automatic logic [CODE_W-1:0] lfsr_step(logic [CODE_W-1:0] s);
    return {s[CODE_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/wdog_lfsr.sv
module wdog_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        adv_i,
  output logic [15:0] code_o
);
  logic [15:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    code_q <= SEED;
    else if (adv_i) code_q <= wdog_pkg::lfsr_step(code_q);
  end

  assign code_o = code_q;
endmodule

// File: rtl/wdog_period.sv
module wdog_period #(
  parameter int unsigned TICKS = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     restart_i,
  input  logic                     tick_i,
  output logic [$clog2(TICKS)-1:0] cnt_o,
  output logic                     open_o,
  output logic                     end_o
);
  localparam int unsigned CW = $clog2(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
  localparam logic [CW-1:0] HALF = CW'(TICKS / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign open_o = (cnt_q >= HALF);
  assign end_o  = tick_i && (cnt_q == LAST);
endmodule

// File: rtl/wdog_refresh_chk.sv
module wdog_refresh_chk
  import wdog_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  ref_mode_e   mode_i,
  input  logic        window_i,
  input  logic        open_i,
  input  logic [15:0] code_i,
  input  logic        cmd_valid_i,
  input  logic [15:0] cmd_data_i,
  output logic        done_o,
  output logic        bad_o
);
  logic [1:0]  seq_q;
  logic [1:0]  last_idx;
  logic [15:0] inv;
  logic [3:0]  nib;
  logic        match;
  logic        time_ok;
  logic        accept;

  assign inv = ~code_i;

  always_comb begin
    unique case (seq_q)
      2'd0:    nib = inv[15:12];
      2'd1:    nib = inv[11:8];
      2'd2:    nib = inv[7:4];
      default: nib = inv[3:0];
    endcase
  end

  always_comb begin
    unique case (mode_i)
      REF_PLAIN: begin last_idx = 2'd0; match = 1'b1; end
      REF_ONE:   begin last_idx = 2'd0; match = (cmd_data_i == inv); end
      REF_TWO:   begin
        last_idx = 2'd1;
        match    = (cmd_data_i[7:0] == (seq_q[0] ? inv[7:0] : inv[15:8]));
      end
      default:   begin last_idx = 2'd3; match = (cmd_data_i[3:0] == nib); end
    endcase
  end

  assign time_ok = !window_i || open_i;
  assign accept  = cmd_valid_i && time_ok && match;
  assign done_o  = accept && (seq_q == last_idx);
  assign bad_o   = cmd_valid_i && !(time_ok && match);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seq_q <= '0;
    else if (clear_i) seq_q <= '0;
    else if (accept)  seq_q <= (seq_q == last_idx) ? 2'd0 : seq_q + 2'd1;
  end
endmodule

// File: rtl/wdog_irq_deadline.sv
module wdog_irq_deadline #(
  parameter int unsigned TICKS = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     chk_en_i,
  input  logic                     raise_i,
  input  logic                     ack_i,
  input  logic                     tick_i,
  input  logic [$clog2(TICKS)-1:0] cnt_i,
  output logic                     expire_o
);
  localparam int unsigned LW = $clog2(3 * TICKS + 1);
  localparam logic [LW-1:0] SPAN = LW'(3 * TICKS);

  logic          pend_q;
  logic [LW-1:0] left_q;

  assign expire_o = pend_q && !ack_i && tick_i && (left_q == LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      left_q <= '0;
    end else if (clear_i) begin
      pend_q <= 1'b0;
      left_q <= '0;
    end else if (pend_q) begin
      if (ack_i)       pend_q <= 1'b0;
      else if (tick_i) left_q <= left_q - 1'b1;
    end else if (raise_i && chk_en_i) begin
      pend_q <= 1'b1;
      left_q <= SPAN - LW'(cnt_i);
    end
  end
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_pkg::*;
#(
  parameter int unsigned TICKS = 8,
  parameter int unsigned RST_W = 16,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             init_mode_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  input  logic             cmd_valid_i,
  input  logic [15:0]      cmd_data_i,
  input  logic             irq_raise_i,
  input  logic             irq_ack_i,
  output logic             rst_o,
  output logic             safe_o,
  output logic [15:0]      code_o
);
  localparam int unsigned CW = $clog2(TICKS);
  localparam int unsigned PW = $clog2(RST_W + 1);

  wd_cfg_t       cfg_q;
  logic          cfg_wr;
  logic [PW-1:0] pulse_q;
  logic          pulsing;
  logic [1:0]    cons_q;
  logic          safe_q;
  logic [CW-1:0] cnt;
  logic          open_w, end_w;
  logic          done, bad, expire, miss, fault, lfsr_adv;

  assign cfg_wr   = cfg_we_i && init_mode_i;
  assign pulsing  = (pulse_q != '0);
  assign miss     = end_w && !done;
  assign fault    = !pulsing && (bad || miss || expire);
  assign lfsr_adv = done && !fault;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (cfg_wr) cfg_q <= wd_cfg_t'(cfg_data_i);
  end

  wdog_period #(.TICKS(TICKS)) u_period (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (pulsing || fault || done),
    .tick_i    (tick_i),
    .cnt_o     (cnt),
    .open_o    (open_w),
    .end_o     (end_w)
  );

  wdog_refresh_chk u_refresh (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (pulsing || fault || cfg_wr),
    .mode_i      (cfg_q.mode),
    .window_i    (cfg_q.window),
    .open_i      (open_w),
    .code_i      (code_o),
    .cmd_valid_i (cmd_valid_i && !pulsing),
    .cmd_data_i  (cmd_data_i),
    .done_o      (done),
    .bad_o       (bad)
  );

  wdog_irq_deadline #(.TICKS(TICKS)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (pulsing || fault),
    .chk_en_i (cfg_q.irq_chk),
    .raise_i  (irq_raise_i),
    .ack_i    (irq_ack_i),
    .tick_i   (tick_i),
    .cnt_i    (cnt),
    .expire_o (expire)
  );

  wdog_lfsr #(.SEED(SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (lfsr_adv),
    .code_o (code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pulse_q <= '0;
    else if (fault)   pulse_q <= PW'(RST_W);
    else if (pulsing) pulse_q <= pulse_q - 1'b1;
  end

  // consecutive faults, saturating at two
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cons_q <= '0;
      safe_q <= 1'b0;
    end else if (fault) begin
      if (cons_q != 2'd2) cons_q <= cons_q + 2'd1;
      if (!cfg_q.safe_second || cons_q != 2'd0) safe_q <= 1'b1;
    end else if (lfsr_adv) begin
      cons_q <= '0;
    end
  end

  assign rst_o  = pulsing;
  assign safe_o = safe_q;
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk #(
  parameter int unsigned RST_W = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        init_mode_i,
  input logic        cfg_we_i,
  input logic [4:0]  cfg_q,
  input logic        fault,
  input logic        lfsr_adv,
  input logic        rst_o,
  input logic        safe_o,
  input logic [15:0] code_o
);
  localparam int unsigned HW = $clog2(RST_W + 2);
  logic [HW-1:0] hi_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_len <= '0;
    else if (rst_o) hi_len <= hi_len + 1'b1;
    else            hi_len <= '0;
  end

  p_cfg_locked_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && init_mode_i) |=> $stable(cfg_q));

  p_fault_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> rst_o);

  p_pulse_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> (hi_len == HW'(RST_W)));

  p_code_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lfsr_adv |=> $stable(code_o));

  p_code_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_adv |=> (code_o != $past(code_o)));

  p_safe_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    safe_o |=> safe_o);

  p_safe_with_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(safe_o) |-> rst_o);
endmodule

bind wdog_supervisor wdog_supervisor_chk #(.RST_W(RST_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_mode_i (init_mode_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_q       (cfg_q),
  .fault       (fault),
  .lfsr_adv    (lfsr_adv),
  .rst_o       (rst_o),
  .safe_o      (safe_o),
  .code_o      (code_o)
);

// File: tb/wdog_supervisor_test.sv
module wdog_supervisor_test;
  localparam int P     = 8;
  localparam int RST_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, init = 1'b0, cfg_we = 1'b0;
  logic [4:0] cfg_data = '0;
  logic cmd_valid = 1'b0;
  logic [15:0] cmd_data = '0;
  logic raise = 1'b0, ack = 1'b0;
  logic rst_o, safe_o;
  logic [15:0] code_o;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  wdog_supervisor uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .init_mode_i(init),
    .cfg_we_i(cfg_we), .cfg_data_i(cfg_data), .cmd_valid_i(cmd_valid),
    .cmd_data_i(cmd_data), .irq_raise_i(raise), .irq_ack_i(ack),
    .rst_o(rst_o), .safe_o(safe_o), .code_o(code_o)
  );

  function automatic logic [15:0] nxt_code(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // tick every 4 cycles
  int tcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin tcnt = 0; tick = 1'b0; end
    else begin tcnt = (tcnt + 1) % 4; tick = (tcnt == 0); end
  end

  // behavioural reference
  int m_pcnt, m_seq, m_pc, m_cons, m_ileft;
  bit m_pend, m_safe;
  logic [15:0] m_code;
  logic [4:0]  m_cfg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pcnt = 0; m_seq = 0; m_pc = 0; m_cons = 0; m_ileft = 0;
      m_pend = 0; m_safe = 0; m_code = 16'hACE1; m_cfg = '0;
    end else begin
      bit pul, flt, dn, ok, tok;
      int mode, nw;
      logic [15:0] inv;
      mode = int'(m_cfg[2:1]);
      nw   = (mode == 3) ? 4 : (mode == 2) ? 2 : 1;
      pul  = (m_pc != 0);
      inv  = ~m_code;
      flt  = 0; dn = 0; ok = 0;
      if (!pul) begin
        if (cmd_valid) begin
          tok = !m_cfg[0] || (m_pcnt >= P / 2);
          case (mode)
            0: ok = 1;
            1: ok = (cmd_data == inv);
            2: ok = (cmd_data[7:0] == ((m_seq == 0) ? inv[15:8] : inv[7:0]));
            default: ok = (cmd_data[3:0] == 4'((inv >> (4 * (3 - m_seq))) & 16'hF));
          endcase
          if (tok && ok) begin if (m_seq == nw - 1) dn = 1; end
          else flt = 1;
        end
        if (tick && m_pcnt == P - 1 && !dn) flt = 1;
        if (m_pend && !ack && tick && m_ileft == 1) flt = 1;
      end
      if (pul || flt) m_pend = 0;
      else if (m_pend) begin
        if (ack) m_pend = 0;
        else if (tick) m_ileft--;
      end else if (raise && m_cfg[3]) begin
        m_pend = 1; m_ileft = 3 * P - m_pcnt;
      end
      if (pul) begin m_pc--; m_pcnt = 0; m_seq = 0; end
      else if (flt) begin
        m_pc = RST_W; m_pcnt = 0; m_seq = 0;
        if (!m_cfg[4] || m_cons >= 1) m_safe = 1;
        if (m_cons < 2) m_cons++;
      end else if (dn) begin
        m_pcnt = 0; m_seq = 0; m_code = nxt_code(m_code); m_cons = 0;
      end else begin
        if (cmd_valid) m_seq++;
        if (tick) m_pcnt++;
      end
      if (cfg_we && init) begin m_cfg = cfg_data; m_seq = 0; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(rst_o == (m_pc != 0), "R8 rst_o vs model", rst_o, m_pc != 0);
      check(safe_o == m_safe, "R11 safe_o vs model", safe_o, m_safe);
      check(code_o == m_code, "R6 code_o vs model", code_o, m_code);
    end
  end

  task automatic nxt();
    @(negedge clk); #1;
  endtask

  task automatic send(logic [15:0] d);
    cmd_valid = 1'b1; cmd_data = d; nxt(); cmd_valid = 1'b0;
  endtask

  task automatic wr_cfg(logic [4:0] v);
    init = 1'b1; cfg_we = 1'b1; cfg_data = v; nxt(); cfg_we = 1'b0; init = 1'b0;
  endtask

  task automatic wait_open();
    while (m_pc != 0 || m_pcnt != P / 2) nxt();
  endtask

  task automatic wait_quiet();
    while (m_pc != 0) nxt();
  endtask

  task automatic irq_case(bit late);
    raise = 1'b1; nxt(); raise = 1'b0;
    for (int g = 0; g < 2000; g++) begin
      if (m_pc == 0 && m_pend && m_ileft == 1 && tick) begin
        if (!late) begin ack = 1'b1; nxt(); ack = 1'b0; end
        else begin nxt(); ack = 1'b1; nxt(); ack = 1'b0; end
        break;
      end
      cmd_valid = (m_pcnt == 2 && m_pc == 0); cmd_data = '0;
      nxt(); cmd_valid = 1'b0;
    end
  endtask

  initial begin
    logic [15:0] c, iv;
    int n;
    bit saw;
    nxt(); nxt(); rst_n = 1'b1; nxt();
    check(rst_o == 0, "R2 rst_o after reset", rst_o, 0);
    check(safe_o == 0, "R2 safe_o after reset", safe_o, 0);
    check(code_o == 16'hACE1, "R2 code seed", code_o, 16'hACE1);

    // R1: write outside init ignored -> still timeout, closed-half refresh ok
    cfg_we = 1'b1; cfg_data = 5'b00001; nxt(); cfg_we = 1'b0;
    c = code_o; send(16'h0);
    check(rst_o == 0, "R1 write outside init ignored", rst_o, 0);
    check(code_o == nxt_code(c), "R4 plain refresh completes", code_o, nxt_code(c));

    // R3/R4 timeout, plain, arbitrary data
    wr_cfg(5'b10000);
    c = code_o; send(16'h1234);
    check(rst_o == 0, "R3 timeout refresh at count 0", rst_o, 0);
    check(code_o == nxt_code(c), "R4 plain any data", code_o, nxt_code(c));

    // R5 one-word challenge in window
    wr_cfg(5'b10011); wait_open();
    c = code_o; send(~c);
    check(rst_o == 0, "R5 one word accepted", rst_o, 0);
    check(code_o == nxt_code(c), "R6 code steps", code_o, nxt_code(c));

    // R5 two words
    wr_cfg(5'b10101); wait_open();
    c = code_o; iv = ~c;
    send({8'h00, iv[15:8]}); send({8'h00, iv[7:0]});
    check(rst_o == 0, "R5 two words accepted", rst_o, 0);
    check(code_o == nxt_code(c), "R5 two words step", code_o, nxt_code(c));

    // R5 four nibbles
    wr_cfg(5'b10111); wait_open();
    c = code_o; iv = ~c;
    send({12'h0, iv[15:12]}); send({12'h0, iv[11:8]});
    send({12'h0, iv[7:4]});   send({12'h0, iv[3:0]});
    check(rst_o == 0, "R5 four words accepted", rst_o, 0);
    check(code_o == nxt_code(c), "R5 four words step", code_o, nxt_code(c));

    // R3 early word in window -> fault; first fault, safe_second set
    iv = ~code_o; send({12'h0, iv[15:12]});
    check(rst_o == 1, "R3 early refresh resets", rst_o, 1);
    check(safe_o == 0, "R11 no safe on first fault", safe_o, 0);
    n = 0;
    while (rst_o) begin n++; nxt(); end
    check(n == RST_W, "R8 pulse width", n, RST_W);

    // R5 wrong nibble -> second consecutive fault -> safe
    wait_open();
    iv = ~code_o; send({12'h0, ~iv[15:12]});
    check(rst_o == 1, "R5 wrong word resets", rst_o, 1);
    check(safe_o == 1, "R11 safe on second fault", safe_o, 1);
    wait_quiet();

    // R7 refresh in final-tick cycle wins
    wr_cfg(5'b10000);
    while (!(m_pc == 0 && m_pcnt == P - 1 && tick)) nxt();
    send(16'h0);
    check(rst_o == 0, "R7 refresh on last tick wins", rst_o, 0);
    check(safe_o == 1, "R11 safe sticky", safe_o, 1);

    // R7 missed refresh
    n = 0;
    while (!rst_o && n < 200) begin n++; nxt(); end
    check(n >= 4 * (P - 1) && n <= 4 * P + 2, "R7 miss resets at period end", n, 4 * P);
    wait_quiet();

    // R9 interrupt deadline
    wr_cfg(5'b11000);
    irq_case(1'b0);
    check(rst_o == 0, "R9 ack on deadline tick in time", rst_o, 0);
    irq_case(1'b1);
    check(rst_o == 1, "R9 ack one cycle late resets", rst_o, 1);
    wait_quiet();

    // R10 deadline disabled
    wr_cfg(5'b10000);
    raise = 1'b1; nxt(); raise = 1'b0;
    saw = 0;
    for (int k = 0; k < 150; k++) begin
      cmd_valid = (m_pcnt == 2 && m_pc == 0); cmd_data = '0;
      nxt(); cmd_valid = 1'b0;
      saw |= rst_o;
    end
    check(!saw, "R10 no deadline when disabled", saw, 0);

    // R11 safe on first fault with default config
    rst_n = 1'b0; nxt(); nxt(); rst_n = 1'b1; nxt();
    check(safe_o == 0, "R2 safe cleared by reset", safe_o, 0);
    while (!rst_o) nxt();
    check(safe_o == 1, "R11 safe on first fault", safe_o, 1);
    wait_quiet(); nxt();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (all R) actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule